// File: doc/BRIEF.md
# Memory Error Healer Remap CAM

This block sits next to the error detect-and-correct logic of a memory controller. Two things feed it: the stream of error reports, each giving an address, the corrected data word and a flag that says whether the error could not be corrected, and the address of every ordinary access. When an error can be corrected and its address is not yet healed, the block takes the lowest-numbered free slot in a 32-entry associative table. It stores the address as the tag and the corrected word in the spare data word paired with that slot. From the next cycle on, an access to that address reports a hit, the slot index and the spare word, so the controller can use the spare word in place of the faulty main-array location. Writes to a healed address go to the spare word.

An uncorrectable error raises a sticky halt request that carries the bank field of the failing address. When every slot is taken, a full flag goes to the processor. Software can read any slot's tag and valid bit, and it can release one slot or all slots, so that healed locations can be retested and the table reused.

Top module: `heal_cam`

## Requirements
- R1: After reset, every slot is invalid and hit_o, full_o and halt_o are 0.
- R2: A correctable error (err_valid_i=1, err_multi_i=0) at an address that no valid slot holds fills the lowest-numbered free slot with that address and the corrected word. From the next cycle, an access to that address gives hit_o=1, hit_idx_o = slot index and spare_rdata_o = the stored word.
- R3: A correctable error at an address that a valid slot already holds takes no second slot. It overwrites that slot's spare word with the new corrected word.
- R4: full_o is 1 exactly while all 32 slots are valid, and it stays 1 until a slot is released. A correctable error at a new address while the table is full fills nothing.
- R5: An uncorrectable error (err_multi_i=1) sets halt_o on the next cycle and fills no slot. halt_bank_o takes the top BANK_W bits of that error's address. Both stay fixed until reset, whatever errors follow.
- R6: An access write (acc_we_i=1) to a healed address replaces that slot's spare word with acc_wdata_i.
- R7: sw_tag_o and sw_valid_o show, in the same cycle, the tag and valid bit of the slot selected by sw_idx_i.
- R8: sw_cmd_i=1 releases the slot at sw_idx_i on the next edge. The next new correctable error then reuses the lowest free slot.
- R9: sw_cmd_i=2 releases all slots on the next edge. sw_cmd_i=0 and sw_cmd_i=3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_valid_i | input | 1 | Error report strobe |
| err_multi_i | input | 1 | Report is an uncorrectable error |
| err_addr_i | input | ADDR_W | Address of the reported error |
| err_data_i | input | DATA_W | Corrected data word |
| acc_addr_i | input | ADDR_W | Access address to look up |
| acc_we_i | input | 1 | Access is a write |
| acc_wdata_i | input | DATA_W | Access write data |
| hit_o | output | 1 | Access address is healed |
| hit_idx_o | output | IDX_W | Slot that matched |
| spare_rdata_o | output | DATA_W | Spare word of the matching slot |
| full_o | output | 1 | All slots in use |
| halt_o | output | 1 | Sticky halt request |
| halt_bank_o | output | BANK_W | Bank field of the first uncorrectable error |
| sw_cmd_i | input | 2 | 0 none, 1 release one, 2 release all, 3 none |
| sw_idx_i | input | IDX_W | Slot selected for read or release |
| sw_tag_o | output | ADDR_W | Tag of the selected slot |
| sw_valid_o | output | 1 | Valid bit of the selected slot |

## Verification
The hardest state to reach from the ports is a full table with a hole in the middle. A 33rd error has to be refused first, and then a release has to make the next error land in exactly that hole and not at the end. The bench fills all 32 slots one after another, with addresses spread by an odd stride. It checks every slot by lookup and by software read, then sends an error at a new address while the table is full. Finally it releases a slot in the middle and watches the next new error take that slot.

// File: rtl/heal_cam_pkg.sv
package heal_cam_pkg;
  typedef enum logic [1:0] {
    SW_NOP     = 2'd0,
    SW_CLR_ONE = 2'd1,
    SW_CLR_ALL = 2'd2,
    SW_RSVD    = 2'd3
  } sw_cmd_e;
endpackage

// File: rtl/heal_cam_lsb_enc.sv
module heal_cam_lsb_enc #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign found_o = |vec_i;
endmodule

// File: rtl/heal_cam_match.sv
module heal_cam_match #(
  parameter int N      = 32,
  parameter int ADDR_W = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]             valid_i,
  input  logic [N-1:0][ADDR_W-1:0] tags_i,
  input  logic [ADDR_W-1:0]        key_i,
  output logic                     hit_o,
  output logic [IW-1:0]            idx_o
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = valid_i[g] && (tags_i[g] == key_i);
  end

  heal_cam_lsb_enc #(.N(N)) u_enc (
    .vec_i  (eq),
    .found_o(hit_o),
    .idx_o  (idx_o)
  );
endmodule

// File: rtl/heal_cam_table.sv
module heal_cam_table #(
  parameter int N      = 32,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int IW = $clog2(N)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     set_en_i,
  input  logic [IW-1:0]            set_idx_i,
  input  logic [ADDR_W-1:0]        set_tag_i,
  input  logic [DATA_W-1:0]        set_data_i,
  input  logic                     dwr_en_i,
  input  logic [IW-1:0]            dwr_idx_i,
  input  logic [DATA_W-1:0]        dwr_data_i,
  input  logic [N-1:0]             clr_mask_i,
  output logic [N-1:0]             valid_o,
  output logic [N-1:0][ADDR_W-1:0] tags_o,
  output logic [N-1:0][DATA_W-1:0] data_o
);
  logic [N-1:0] set_oh;
  assign set_oh = set_en_i ? (N'(1) << set_idx_i) : '0;

  // allocation wins over a release of the same slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= '0;
    else         valid_o <= (valid_o & ~clr_mask_i) | set_oh;
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tags_o[g] <= '0;
        data_o[g] <= '0;
      end else if (set_oh[g]) begin
        tags_o[g] <= set_tag_i;
        data_o[g] <= set_data_i;
      end else if (dwr_en_i && dwr_idx_i == IW'(g)) begin
        data_o[g] <= dwr_data_i;
      end
    end
  end
endmodule

// File: rtl/heal_cam.sv
module heal_cam
  import heal_cam_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int BANK_W  = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_valid_i,
  input  logic              err_multi_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [DATA_W-1:0] err_data_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_we_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [DATA_W-1:0] spare_rdata_o,
  output logic              full_o,
  output logic              halt_o,
  output logic [BANK_W-1:0] halt_bank_o,
  input  logic [1:0]        sw_cmd_i,
  input  logic [IDX_W-1:0]  sw_idx_i,
  output logic [ADDR_W-1:0] sw_tag_o,
  output logic              sw_valid_o
);
  logic [ENTRIES-1:0]             valid;
  logic [ENTRIES-1:0][ADDR_W-1:0] tags;
  logic [ENTRIES-1:0][DATA_W-1:0] data;

  logic             err_single, e_hit, f_found, set_en, dwr_en;
  logic [IDX_W-1:0] e_idx, f_idx, dwr_idx;
  logic [DATA_W-1:0] dwr_data;
  logic [ENTRIES-1:0] clr_mask;

  assign err_single = err_valid_i && !err_multi_i;

  heal_cam_match #(.N(ENTRIES), .ADDR_W(ADDR_W)) u_acc_match (
    .valid_i(valid), .tags_i(tags), .key_i(acc_addr_i),
    .hit_o(hit_o), .idx_o(hit_idx_o)
  );

  heal_cam_match #(.N(ENTRIES), .ADDR_W(ADDR_W)) u_err_match (
    .valid_i(valid), .tags_i(tags), .key_i(err_addr_i),
    .hit_o(e_hit), .idx_o(e_idx)
  );

  heal_cam_lsb_enc #(.N(ENTRIES)) u_free (
    .vec_i(~valid), .found_o(f_found), .idx_o(f_idx)
  );

  assign set_en = err_single && !e_hit && f_found;

  // repeat error refreshes the spare word, otherwise a write to a healed address
  always_comb begin
    dwr_en   = 1'b0;
    dwr_idx  = hit_idx_o;
    dwr_data = acc_wdata_i;
    if (err_single && e_hit) begin
      dwr_en   = 1'b1;
      dwr_idx  = e_idx;
      dwr_data = err_data_i;
    end else if (acc_we_i && hit_o) begin
      dwr_en = 1'b1;
    end
  end

  always_comb begin
    unique case (sw_cmd_e'(sw_cmd_i))
      SW_CLR_ONE: clr_mask = ENTRIES'(1) << sw_idx_i;
      SW_CLR_ALL: clr_mask = '1;
      default:    clr_mask = '0;
    endcase
  end

  heal_cam_table #(.N(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_en_i  (set_en),
    .set_idx_i (f_idx),
    .set_tag_i (err_addr_i),
    .set_data_i(err_data_i),
    .dwr_en_i  (dwr_en),
    .dwr_idx_i (dwr_idx),
    .dwr_data_i(dwr_data),
    .clr_mask_i(clr_mask),
    .valid_o   (valid),
    .tags_o    (tags),
    .data_o    (data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_o      <= 1'b0;
      halt_bank_o <= '0;
    end else if (err_valid_i && err_multi_i && !halt_o) begin
      halt_o      <= 1'b1;
      halt_bank_o <= err_addr_i[ADDR_W-1 -: BANK_W];
    end
  end

  assign full_o        = &valid;
  assign spare_rdata_o = data[hit_idx_o];
  assign sw_tag_o      = tags[sw_idx_i];
  assign sw_valid_o    = valid[sw_idx_i];
endmodule

// File: rtl/heal_cam_chk.sv
module heal_cam_chk #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              err_valid_i,
  input logic              err_multi_i,
  input logic [ADDR_W-1:0] err_addr_i,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              hit_o,
  input logic              full_o,
  input logic              halt_o,
  input logic [BANK_W-1:0] halt_bank_o,
  input logic [1:0]        sw_cmd_i
);
  p_alloc_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_i && !err_multi_i && !full_o && sw_cmd_i == 2'd0)
    |=> (acc_addr_i != $past(err_addr_i) || hit_o));

  p_full_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && (sw_cmd_i == 2'd0 || sw_cmd_i == 2'd3)) |=> full_o);

  p_halt_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_i && err_multi_i) |=> halt_o);

  p_halt_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (halt_o && $stable(halt_bank_o)));

  p_clr_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_cmd_i == 2'd1 && !err_valid_i) |=> !full_o);

  p_clr_all_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_cmd_i == 2'd2 && !err_valid_i) |=> (!full_o && !hit_o));
endmodule

bind heal_cam heal_cam_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .err_valid_i(err_valid_i),
  .err_multi_i(err_multi_i),
  .err_addr_i (err_addr_i),
  .acc_addr_i (acc_addr_i),
  .hit_o      (hit_o),
  .full_o     (full_o),
  .halt_o     (halt_o),
  .halt_bank_o(halt_bank_o),
  .sw_cmd_i   (sw_cmd_i)
);

// File: tb/heal_cam_bench.sv
module heal_cam_bench;
  localparam int N = 32, AW = 16, DW = 32, BW = 2, IW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic err_valid = 0, err_multi = 0, acc_we = 0;
  logic [AW-1:0] err_addr = '0, acc_addr = '0;
  logic [DW-1:0] err_data = '0, acc_wdata = '0;
  logic [1:0] sw_cmd = '0;
  logic [IW-1:0] sw_idx = '0;
  logic hit, full, halt, sw_valid;
  logic [IW-1:0] hit_idx;
  logic [DW-1:0] spare;
  logic [BW-1:0] bank;
  logic [AW-1:0] sw_tag;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  heal_cam u_heal_cam (
    .clk_i(clk), .rst_ni(rst_n),
    .err_valid_i(err_valid), .err_multi_i(err_multi),
    .err_addr_i(err_addr), .err_data_i(err_data),
    .acc_addr_i(acc_addr), .acc_we_i(acc_we), .acc_wdata_i(acc_wdata),
    .hit_o(hit), .hit_idx_o(hit_idx), .spare_rdata_o(spare),
    .full_o(full), .halt_o(halt), .halt_bank_o(bank),
    .sw_cmd_i(sw_cmd), .sw_idx_i(sw_idx),
    .sw_tag_o(sw_tag), .sw_valid_o(sw_valid)
  );

  function automatic logic [AW-1:0] a_of(int k);
    return AW'(16'h1000 + k * 7);
  endfunction
  function automatic logic [DW-1:0] d_of(int k);
    return DW'(k) * 32'h0101_0101 ^ 32'hA5A5_0000;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report(logic [AW-1:0] a, logic [DW-1:0] d, logic m);
    @(negedge clk);
    err_valid = 1; err_multi = m; err_addr = a; err_data = d;
    @(negedge clk);
    err_valid = 0; err_multi = 0;
  endtask

  task automatic sw(logic [1:0] c, logic [IW-1:0] i);
    @(negedge clk);
    sw_cmd = c; sw_idx = i;
    @(negedge clk);
    sw_cmd = 0;
  endtask

  task automatic look(string req, logic [AW-1:0] a, logic eh, int ei, logic [DW-1:0] ed);
    acc_addr = a; #1;
    check(req, DW'(hit), DW'(eh));
    if (eh) begin
      check(req, DW'(hit_idx), DW'(ei));
      check(req, spare, ed);
    end
  endtask

  task automatic peek(string req, int i, logic ev, logic [AW-1:0] et);
    sw_idx = IW'(i); #1;
    check(req, DW'(sw_valid), DW'(ev));
    if (ev) check(req, DW'(sw_tag), DW'(et));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < N; i++) peek("R1", i, 0, '0);
    look("R1", a_of(0), 0, 0, '0);
    check("R1", DW'(full), 0);
    check("R1", DW'(halt), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 fill slots 0..3 in order
    for (int k = 0; k < 4; k++) begin
      report(a_of(k), d_of(k), 0);
      look("R2", a_of(k), 1, k, d_of(k));
      peek("R7", k, 1, a_of(k));
    end
    // R3 repeat error on healed address
    report(a_of(1), 32'hDEAD_BEEF, 0);
    look("R3", a_of(1), 1, 1, 32'hDEAD_BEEF);
    peek("R3", 4, 0, '0);
    report(a_of(1), d_of(1), 0);
    // R6 write through healed address
    @(negedge clk);
    acc_addr = a_of(2); acc_we = 1; acc_wdata = 32'h1234_5678;
    @(negedge clk);
    acc_we = 0;
    look("R6", a_of(2), 1, 2, 32'h1234_5678);
    acc_addr = 16'h0F00; acc_we = 1; acc_wdata = 32'h5555_5555;
    @(negedge clk);
    acc_we = 0;
    look("R6", 16'h0F00, 0, 0, '0);
    look("R6", a_of(2), 1, 2, 32'h1234_5678);
    report(a_of(2), d_of(2), 0);

    // fill remaining slots, full only at the last
    for (int k = 4; k < N; k++) begin
      check("R4", DW'(full), 0);
      report(a_of(k), d_of(k), 0);
    end
    check("R4", DW'(full), 1);
    for (int k = 0; k < N; k++) begin
      look("R2", a_of(k), 1, k, d_of(k));
      peek("R7", k, 1, a_of(k));
    end
    // R4 error while full
    report(16'h7777, 32'h0BAD_0BAD, 0);
    look("R4", 16'h7777, 0, 0, '0);
    check("R4", DW'(full), 1);
    // R9 reserved and nop commands
    sw(2'd3, 5'd7);
    sw(2'd0, 5'd7);
    check("R9", DW'(full), 1);
    peek("R9", 7, 1, a_of(7));

    // R8 release slot 13, reuse it
    sw(2'd1, 5'd13);
    check("R8", DW'(full), 0);
    peek("R8", 13, 0, '0);
    look("R8", a_of(13), 0, 0, '0);
    peek("R8", 14, 1, a_of(14));
    report(16'h7777, 32'hCAFE_F00D, 0);
    look("R8", 16'h7777, 1, 13, 32'hCAFE_F00D);
    check("R4", DW'(full), 1);

    // R9 release all
    sw(2'd2, 5'd0);
    check("R9", DW'(full), 0);
    for (int i = 0; i < N; i++) peek("R9", i, 0, '0);
    report(a_of(20), d_of(20), 0);
    look("R9", a_of(20), 1, 0, d_of(20));

    // R5 uncorrectable errors
    check("R5", DW'(halt), 0);
    report(16'hC123, 32'h0, 1);
    check("R5", DW'(halt), 1);
    check("R5", DW'(bank), 3);
    look("R5", 16'hC123, 0, 0, '0);
    peek("R5", 1, 0, '0);
    report(16'h4000, 32'h0, 1);
    check("R5", DW'(bank), 3);
    check("R5", DW'(halt), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule